// File: doc/BRIEF.md
# Code-Group Synchronization Tracker

This block follows a stream of code groups that an upstream aligner has already placed on word boundaries. It keeps one flag that says whether the link is synchronized. Each clock cycle may carry one code group, marked by a valid strobe. Two qualifiers travel with the group. One says the group is a synchronization code group. The other says the group is erroneous.

The tracker starts hunting for lock. It declares lock once it has counted a build-time number of good synchronization groups. While locked, it counts errors that arrive back to back. When that run reaches a second build-time number, it drops lock. Any good group inside the run clears the run. After a drop, the hunt starts again from zero. The flag is a level, not a pulse. Downstream logic gates its use of received data with it.

Top module: `cgsync_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the tracker enters the hunting state with both counters at zero, and `sync_ok` reads 0 after that edge.
- R2: While hunting, `sync_ok` goes to 1 right after the clock edge that samples the ACQ_COUNT-th good synchronization group. A good synchronization group is valid=1, is_sync=1, is_err=0.
- R3: While hunting, valid groups with is_sync=0 neither advance nor clear the acquisition count. Good synchronization groups therefore accumulate even when other groups sit between them.
- R4: While locked, `sync_ok` stays at 1 as long as fewer than LOSS_COUNT erroneous groups (valid=1, is_err=1) have arrived back to back.
- R5: While locked, `sync_ok` goes to 0 right after the edge that samples the LOSS_COUNT-th erroneous group in an unbroken run.
- R6: While locked, a valid group with is_err=0 resets the error run to zero, whatever its is_sync value.
- R7: A group with is_err=1 counts as erroneous even when is_sync=1. It never advances acquisition.
- R8: A cycle with valid=0 changes neither the state nor either counter, whatever the qualifier inputs are.
- R9: Dropping lock clears the acquisition count. Good synchronization groups received before the drop do not count toward the next lock.
- R10: Both counters saturate at their limits and never wrap. The design is correct for limits as small as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_valid | input | 1 | A code group is present this cycle |
| grp_is_sync | input | 1 | The present group is a synchronization code group |
| grp_is_err | input | 1 | The present group is erroneous |
| sync_ok | output | 1 | Synchronization status level |

## Verification
Two situations are hard to reach on purpose. The first is an error run that stops exactly one group short of the loss limit and then resumes after a single good group. The second is a drop of lock that happens while acquisition credit from before the lock still seems relevant. Directed sequences build both situations on two instances, one at the default limits and one with both limits at 1. A long pseudo-random sweep with errors weighted heavily then checks both instances every cycle against an arithmetic model of the two counters.

// File: rtl/cgsync_pkg.sv
// Package: shared types for the code-group synchronization tracker.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cgsync_pkg;

    // Two-state machine: hunting for lock, or locked.
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } cgsync_state_t;

endpackage

// File: rtl/cgsync_run_counter.sv
// Module: saturating up-counter with synchronous clear.
// What it does: counts inc pulses up to LIMIT and then holds there. Clear wins over inc.
// It also flags when the current inc would make the count reach LIMIT.
// Assumes: LIMIT >= 1; clr and inc are qualified by the caller.
module cgsync_run_counter #(
    parameter int LIMIT = 3,
    localparam int CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          reach
);
    localparam logic [CW-1:0] LIM   = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M = CW'(LIMIT - 1);

    // Count register: reset, clear, or saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && (cnt != LIM))
            cnt <= cnt + 1'b1;
    end

    // Flag that the pending increment lands exactly on the limit.
    always_comb reach = inc && (cnt == LIM_M);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM)
        else $error("R10: counter above limit");

    a_r10_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIM && !clr) |=> cnt == LIM)
        else $error("R10: saturated counter moved without clear");

endmodule

// File: rtl/cgsync_ctrl.sv
// Module: state machine for synchronization acquisition and loss.
// What it does: sorts each valid group into good-sync, good, or erroneous.
// It drives the counters' inc and clear controls and moves between hunting and locked.
// Assumes: acq_reach and loss_reach come from counters that this module controls.
module cgsync_ctrl
    import cgsync_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_valid,
    input  logic          grp_is_sync,
    input  logic          grp_is_err,
    input  logic          acq_reach,
    input  logic          loss_reach,
    output cgsync_state_t state,
    output logic          acq_inc,
    output logic          acq_clr,
    output logic          loss_inc,
    output logic          loss_clr
);
    logic          grp_good;
    logic          grp_sgood;
    logic          grp_bad;
    cgsync_state_t state_nx;

    // Sort the present group; an error flag overrides the sync flag.
    always_comb begin
        grp_bad   = grp_valid && grp_is_err;
        grp_good  = grp_valid && !grp_is_err;
        grp_sgood = grp_good && grp_is_sync;
    end

    // Next state and counter controls.
    always_comb begin
        state_nx = state;
        acq_inc  = 1'b0;
        acq_clr  = 1'b0;
        loss_inc = 1'b0;
        loss_clr = 1'b0;
        unique case (state)
            ST_HUNT: begin
                acq_inc = grp_sgood;
                if (grp_sgood && acq_reach) begin
                    state_nx = ST_LOCKED;
                    loss_clr = 1'b1;
                end
            end
            ST_LOCKED: begin
                loss_inc = grp_bad;
                loss_clr = grp_good;
                if (grp_bad && loss_reach) begin
                    state_nx = ST_HUNT;
                    acq_clr  = 1'b1;
                    loss_clr = 1'b1;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= state_nx;
    end

    a_r7_err_never_acquires: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && grp_is_err) |=> state == ST_HUNT)
        else $error("R7: erroneous group caused lock");

endmodule

// File: rtl/cgsync_tracker.sv
// Module: top of the code-group synchronization tracker.
// What it does: sync_ok is high while the locked state holds. Lock comes after ACQ_COUNT
// good sync groups and goes after LOSS_COUNT errors in a row.
// Assumes: input groups are already word-aligned; ACQ_COUNT >= 1, LOSS_COUNT >= 1.
module cgsync_tracker
    import cgsync_pkg::*;
#(
    parameter int ACQ_COUNT  = 3,
    parameter int LOSS_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grp_valid,
    input  logic grp_is_sync,
    input  logic grp_is_err,
    output logic sync_ok
);
    localparam int ACW = (ACQ_COUNT  < 2) ? 1 : $clog2(ACQ_COUNT + 1);
    localparam int LCW = (LOSS_COUNT < 2) ? 1 : $clog2(LOSS_COUNT + 1);

    cgsync_state_t  state;
    logic           acq_inc, acq_clr, acq_reach;
    logic           loss_inc, loss_clr, loss_reach;
    logic [ACW-1:0] acq_cnt;
    logic [LCW-1:0] loss_cnt;

    initial begin
        if (ACQ_COUNT < 1 || LOSS_COUNT < 1)
            $error("cgsync_tracker: limits must be at least 1");
    end

    cgsync_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_valid  (grp_valid),
        .grp_is_sync(grp_is_sync),
        .grp_is_err (grp_is_err),
        .acq_reach  (acq_reach),
        .loss_reach (loss_reach),
        .state      (state),
        .acq_inc    (acq_inc),
        .acq_clr    (acq_clr),
        .loss_inc   (loss_inc),
        .loss_clr   (loss_clr)
    );

    cgsync_run_counter #(.LIMIT(ACQ_COUNT)) u_acq (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acq_clr),
        .inc  (acq_inc),
        .cnt  (acq_cnt),
        .reach(acq_reach)
    );

    cgsync_run_counter #(.LIMIT(LOSS_COUNT)) u_loss (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (loss_clr),
        .inc  (loss_inc),
        .cnt  (loss_cnt),
        .reach(loss_reach)
    );

    // Status level decoded from the state register.
    always_comb sync_ok = (state == ST_LOCKED);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!sync_ok && acq_cnt == '0 && loss_cnt == '0))
        else $error("R1: reset did not clear state");

    a_r2_rise_on_sync_group: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(grp_valid && grp_is_sync && !grp_is_err))
        else $error("R2: lock without a good sync group");

    a_r5_fall_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> $past(grp_valid && grp_is_err))
        else $error("R5: lock dropped without an error");

    a_r6_good_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && grp_valid && !grp_is_err) |=> loss_cnt == '0)
        else $error("R6: good group left error run");

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> ($stable(sync_ok) && $stable(acq_cnt) && $stable(loss_cnt)))
        else $error("R8: idle cycle changed state");

    a_r9_drop_clears_acq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> (acq_cnt == '0 && loss_cnt == '0))
        else $error("R9: drop left counts");

endmodule

// File: tb/cgsync_tracker_bench.sv
`timescale 1ns/1ps
module cgsync_tracker_bench;
    localparam int A0 = 3, L0 = 4;   // instance a: defaults
    localparam int A1 = 1, L1 = 1;   // instance b: minimal limits (R10)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v = 1'b0, s = 1'b0, e = 1'b0;
    logic ok_a, ok_b;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    int   st_a = 0, ac_a = 0, lc_a = 0;
    int   st_b = 0, ac_b = 0, lc_b = 0;

    always #2.5 clk = ~clk;

    cgsync_tracker #(.ACQ_COUNT(A0), .LOSS_COUNT(L0)) u_cgsync_tracker (
        .clk(clk), .rst_n(rst_n), .grp_valid(v), .grp_is_sync(s),
        .grp_is_err(e), .sync_ok(ok_a));

    cgsync_tracker #(.ACQ_COUNT(A1), .LOSS_COUNT(L1)) u_cgsync_tracker_min (
        .clk(clk), .rst_n(rst_n), .grp_valid(v), .grp_is_sync(s),
        .grp_is_err(e), .sync_ok(ok_b));

    // Arithmetic model of one tracker, stepped once per clock edge.
    task automatic model_step(inout int st, inout int ac, inout int lc,
                              input int lim_a, input int lim_l,
                              input bit mv, input bit ms, input bit me);
        if (mv) begin
            if (st == 0) begin
                if (ms && !me) begin
                    ac = ac + 1;
                    if (ac >= lim_a) begin st = 1; lc = 0; end
                end
            end else if (me) begin
                lc = lc + 1;
                if (lc >= lim_l) begin st = 0; ac = 0; lc = 0; end
            end else begin
                lc = 0;
            end
        end
    endtask

    task automatic check(input string tag, input logic act, input int exp_v);
        n_chk++;
        if (act !== exp_v[0]) begin
            n_fail++;
            $display("FAIL %s: sync_ok=%0b expected %0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Drive one cycle at the falling edge, step the models at the rising edge, compare after.
    task automatic apply(input string tag, input bit nv, input bit ns, input bit ne);
        @(negedge clk);
        v = nv; s = ns; e = ne;
        @(posedge clk);
        #1;
        model_step(st_a, ac_a, lc_a, A0, L0, nv, ns, ne);
        model_step(st_b, ac_b, lc_b, A1, L1, nv, ns, ne);
        check(tag, ok_a, st_a);
        check({tag, "/min"}, ok_b, st_b);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit [31:0] r;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", ok_a, 0);
        check("R1/min", ok_b, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: idle cycles with qualifiers set do nothing while hunting
        for (int i = 0; i < 4; i++) apply("R8", 0, 1, 0);
        // R7: sync flag with error never acquires
        for (int i = 0; i < 3; i++) apply("R7", 1, 1, 1);
        // R3: sync groups interleaved with non-sync and idle groups still accumulate
        apply("R3", 1, 1, 0);
        apply("R3", 1, 0, 0);
        apply("R3", 1, 0, 1);
        apply("R3", 0, 1, 0);
        apply("R3", 1, 1, 0);
        apply("R3", 1, 0, 0);
        // R2: the third good sync group locks instance a
        apply("R2", 1, 1, 0);
        // R4/R6: runs one short of the limit, broken by one good group
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < L0 - 1; i++) apply("R4", 1, 0, 1);
            apply("R6", 1, k[0], 0);
        end
        // R8: idle cycles inside an error run neither break nor extend it
        for (int i = 0; i < L0 - 1; i++) begin
            apply("R8", 1, 0, 1);
            apply("R8", 0, 0, 0);
        end
        // R5: the last error of the run drops lock
        apply("R5", 1, 0, 1);
        // R9: earlier credit is gone; ACQ_COUNT-1 syncs do not lock
        for (int i = 0; i < A0 - 1; i++) apply("R9", 1, 1, 0);
        apply("R9", 1, 1, 0);
        // R7: an error carrying the sync flag counts as an error while locked
        for (int i = 0; i < L0; i++) apply("R7", 1, 1, 1);
        // R10: long saturation runs of sync groups, then errors
        for (int i = 0; i < 12; i++) apply("R10", 1, 1, 0);
        for (int i = 0; i < 12; i++) apply("R10", 1, 1, 1);
        // R10 sweep: pseudo-random groups, errors weighted heavily
        r = 32'h1bad_5eed;
        for (int i = 0; i < 4000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            apply("R10", r[0] | r[1], r[3:2] != 2'd0, r[6:4] < 3'd4);
        end
        // R1: reset from the locked state
        for (int i = 0; i < A0; i++) apply("R1", 1, 1, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        st_a = 0; ac_a = 0; lc_a = 0; st_b = 0; ac_b = 0; lc_b = 0;
        check("R1", ok_a, 0);
        check("R1/min", ok_b, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule